// File: doc/BRIEF.md
# Radix-2 DIF Butterfly with Deferred Twiddle Multiply

This block is the arithmetic core of a memory-based radix-2 decimation-in-frequency FFT engine. Each accepted cycle takes two complex operands, x and y, and forms their half-scaled sum and half-scaled difference. The sum is final for the stage, so it leaves on its own output port one cycle later without ever touching the multiplier. The difference is the only value that needs a twiddle factor. It either goes to the single complex multiplier at once, or it is parked in a small scratch store until a later phase multiplies it.

A mode pin selects the behaviour. Direct mode serves the first stage: the difference is multiplied in the same cycle and the scratch store is left alone. Deferred mode serves the later stages, where the data splits into two independent halves. While the adder works on one half, the multiplier consumes the difference that the other half parked at the same scratch address. The scratch entry is read before it is overwritten, so one multiplier is kept busy on every cycle. A flush strobe drains parked differences at the end of a pass without offering new operands.

Twiddle values, bank addressing and input/output buffering come from outside. The twiddle presented in a cycle belongs to the value that is being multiplied in that cycle.

Top module: `dif_split_butterfly`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with neither in_valid nor flush high, sum_valid and prod_valid are 0.
- R2: One cycle after in_valid is high, sum_valid is 1 and sum_re/sum_im equal (x+y)>>>1 per component, computed in 17 bits, with floor rounding. The sum does not depend on the twiddle inputs. sum_valid is 0 one cycle after in_valid is low.
- R3: In direct mode (mode=1), one cycle after in_valid the product of the difference d=(x−y)>>>1 and the current twiddle appears with prod_valid=1. Direct-mode cycles leave the scratch store unchanged.
- R4: The product is computed as follows. p_re = low 16 bits of ((d_re·w_re − d_im·w_im + 2^14) >>> 15) and p_im = low 16 bits of ((d_re·w_im + d_im·w_re + 2^14) >>> 15). The twiddle is a signed value with 15 fraction bits.
- R5: In deferred mode (mode=0), an in_valid cycle stores d at scratch address addr. If that entry was empty, no product follows (prod_valid=0).
- R6: In deferred mode, an in_valid cycle at an occupied address produces, one cycle later, the product of the previously parked value with the current twiddle. The new difference replaces that entry (read before write).
- R7: In deferred mode, a flush cycle with in_valid=0 on an occupied address produces that entry's product one cycle later and empties the entry. On an empty address it produces no product.
- R8: With all entries occupied, back-to-back deferred cycles yield prod_valid=1 and sum_valid=1 on every cycle.
- R9: flush is ignored when in_valid is 1, and it is ignored in direct mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operands x, y are present this cycle |
| mode | input | 1 | 1 = direct multiply, 0 = deferred through scratch |
| flush | input | 1 | Multiply and release the parked entry at addr (deferred mode, no operands) |
| addr | input | AW | Scratch address of the current butterfly |
| x_re | input | DW | Operand x, real part |
| x_im | input | DW | Operand x, imaginary part |
| y_re | input | DW | Operand y, real part |
| y_im | input | DW | Operand y, imaginary part |
| tw_re | input | TW | Twiddle for the value multiplied this cycle, real part |
| tw_im | input | TW | Twiddle for the value multiplied this cycle, imaginary part |
| sum_valid | output | 1 | Sum output valid |
| sum_re | output | DW | Half-scaled sum, real part |
| sum_im | output | DW | Half-scaled sum, imaginary part |
| prod_valid | output | 1 | Product output valid |
| prod_re | output | DW | Rounded twiddle product, real part |
| prod_im | output | DW | Rounded twiddle product, imaginary part |

## Verification
Direct mode is driven with full-scale and sign-extreme operands and twiddles. This separates correct half-scaling, floor rounding and product wrap from off-by-one shift errors. A deferred first pass over empty entries followed by a second pass over the same addresses shows whether the multiplied value is the old parked one or the new one, which exposes a write-before-read. Flushes over full and then empty entries, flush raised together with in_valid, and long random mixes of the two modes check occupancy tracking and its interaction with direct mode against a behavioural model.

// File: rtl/sbf_pkg.sv
`timescale 1ns/1ps
package sbf_pkg;
  typedef enum logic {
    MODE_DEFER  = 1'b0,
    MODE_DIRECT = 1'b1
  } sbf_mode_e;
  localparam int LANES = 2;  // real and imaginary
endpackage

// File: rtl/sbf_addsub.sv
`timescale 1ns/1ps
module sbf_addsub #(
  parameter int DW = 16
) (
  input  logic signed [sbf_pkg::LANES-1:0][DW-1:0] x_i,
  input  logic signed [sbf_pkg::LANES-1:0][DW-1:0] y_i,
  output logic signed [sbf_pkg::LANES-1:0][DW-1:0] s_o,
  output logic signed [sbf_pkg::LANES-1:0][DW-1:0] d_o
);
  for (genvar g = 0; g < sbf_pkg::LANES; g++) begin : g_lane
    logic signed [DW:0] wide_s;
    logic signed [DW:0] wide_d;
    always_comb begin
      wide_s = {x_i[g][DW-1], x_i[g]} + {y_i[g][DW-1], y_i[g]};
      wide_d = {x_i[g][DW-1], x_i[g]} - {y_i[g][DW-1], y_i[g]};
      s_o[g] = wide_s[DW:1];
      d_o[g] = wide_d[DW:1];
    end
  end
endmodule

// File: rtl/sbf_cmul.sv
`timescale 1ns/1ps
module sbf_cmul #(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [TW-1:0] w_re,
  input  logic signed [TW-1:0] w_im,
  output logic                 out_vld,
  output logic signed [DW-1:0] p_re,
  output logic signed [DW-1:0] p_im
);
  localparam int FRAC = TW - 1;
  localparam int PW   = DW + TW + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);

  logic signed [PW-1:0] acc_re, acc_im, rnd_re, rnd_im, sh_re, sh_im;
  logic signed [DW-1:0] p_re_d, p_im_d;
  logic                 vld_q;
  logic signed [DW-1:0] p_re_q, p_im_q;

  always_comb begin
    acc_re = PW'(a_re) * PW'(w_re) - PW'(a_im) * PW'(w_im);
    acc_im = PW'(a_re) * PW'(w_im) + PW'(a_im) * PW'(w_re);
    rnd_re = acc_re + HALF;
    rnd_im = acc_im + HALF;
    sh_re  = rnd_re >>> FRAC;
    sh_im  = rnd_im >>> FRAC;
    p_re_d = sh_re[DW-1:0];
    p_im_d = sh_im[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      p_re_q <= p_re_d;
      p_im_q <= p_im_d;
    end
  end

  assign out_vld = vld_q;
  assign p_re    = p_re_q;
  assign p_im    = p_im_q;

  assert_mul_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  assert_mul_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
endmodule

// File: rtl/sbf_scratch.sv
`timescale 1ns/1ps
module sbf_scratch #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic                 put,
  input  logic                 take,
  input  logic signed [DW-1:0] wr_re,
  input  logic signed [DW-1:0] wr_im,
  output logic                 hit,
  output logic signed [DW-1:0] rd_re,
  output logic signed [DW-1:0] rd_im
);
  logic [DW-1:0]    mem_re [DEPTH];
  logic [DW-1:0]    mem_im [DEPTH];
  logic [DEPTH-1:0] occ_q, occ_d;

  always_comb begin
    hit   = take & occ_q[addr];
    rd_re = mem_re[addr];
    rd_im = mem_im[addr];
    occ_d = occ_q;
    if (put)       occ_d[addr] = 1'b1;
    else if (take) occ_d[addr] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  always_ff @(posedge clk) begin
    if (put) begin
      mem_re[addr] <= wr_re;
      mem_im[addr] <= wr_im;
    end
  end

  assert_park_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    put |=> occ_q[$past(addr)]);
  assert_flush_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !put) |=> !occ_q[$past(addr)]);
  assert_idle_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !put) |=> $stable(occ_q));
endmodule

// File: rtl/dif_split_butterfly.sv
`timescale 1ns/1ps
module dif_split_butterfly #(
  parameter int DW    = 16,
  parameter int TW    = 16,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 mode,
  input  logic                 flush,
  input  logic [AW-1:0]        addr,
  input  logic signed [DW-1:0] x_re,
  input  logic signed [DW-1:0] x_im,
  input  logic signed [DW-1:0] y_re,
  input  logic signed [DW-1:0] y_im,
  input  logic signed [TW-1:0] tw_re,
  input  logic signed [TW-1:0] tw_im,
  output logic                 sum_valid,
  output logic signed [DW-1:0] sum_re,
  output logic signed [DW-1:0] sum_im,
  output logic                 prod_valid,
  output logic signed [DW-1:0] prod_re,
  output logic signed [DW-1:0] prod_im
);
  import sbf_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  sbf_mode_e mode_e;
  logic signed [LANES-1:0][DW-1:0] xv, yv, sv, dv;
  logic                 direct, put, take, hit, mul_vld;
  logic signed [DW-1:0] park_re, park_im, mop_re, mop_im;
  logic                 sum_vld_q;
  logic signed [DW-1:0] sum_re_q, sum_im_q;

  always_comb begin
    mode_e  = sbf_mode_e'(mode);
    xv      = {x_im, x_re};
    yv      = {y_im, y_re};
    direct  = (mode_e == MODE_DIRECT);
    put     = in_valid & ~direct;
    take    = ~direct & (in_valid | flush);
    mul_vld = (in_valid & direct) | hit;
    mop_re  = direct ? dv[0] : park_re;
    mop_im  = direct ? dv[1] : park_im;
  end

  sbf_addsub #(.DW(DW)) u_addsub (
    .x_i(xv), .y_i(yv), .s_o(sv), .d_o(dv)
  );

  sbf_scratch #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_scratch (
    .clk(clk), .rst_n(rst_n_s), .addr(addr), .put(put), .take(take),
    .wr_re(dv[0]), .wr_im(dv[1]), .hit(hit), .rd_re(park_re), .rd_im(park_im)
  );

  sbf_cmul #(.DW(DW), .TW(TW)) u_cmul (
    .clk(clk), .rst_n(rst_n_s), .in_vld(mul_vld),
    .a_re(mop_re), .a_im(mop_im), .w_re(tw_re), .w_im(tw_im),
    .out_vld(prod_valid), .p_re(prod_re), .p_im(prod_im)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) sum_vld_q <= 1'b0;
    else          sum_vld_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      sum_re_q <= sv[0];
      sum_im_q <= sv[1];
    end
  end

  assign sum_valid = sum_vld_q;
  assign sum_re    = sum_re_q;
  assign sum_im    = sum_im_q;

  assert_sum_latency_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    in_valid |=> sum_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!in_valid && !flush) |=> (!sum_valid && !prod_valid));
  assert_direct_prod_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && mode) |=> prod_valid);
  assert_direct_flush_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode && !in_valid) |=> !prod_valid);
endmodule

// File: tb/sim_dif_split_butterfly.sv
`timescale 1ns/1ps
module sim_dif_split_butterfly;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, mode, flush;
  logic [AW-1:0] addr;
  logic signed [15:0] x_re, x_im, y_re, y_im, tw_re, tw_im;
  logic sum_valid, prod_valid;
  logic signed [15:0] sum_re, sum_im, prod_re, prod_im;

  always #4 clk = ~clk;

  dif_split_butterfly #(.DW(16), .TW(16), .DEPTH(DEPTH), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .flush(flush),
    .addr(addr), .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
    .tw_re(tw_re), .tw_im(tw_im), .sum_valid(sum_valid), .sum_re(sum_re),
    .sum_im(sum_im), .prod_valid(prod_valid), .prod_re(prod_re), .prod_im(prod_im)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // behavioural model state
  int park_re [DEPTH];
  int park_im [DEPTH];
  bit occ [DEPTH];
  bit e_sv = 0, e_pv = 0;
  int e_sre, e_sim, e_pre, e_pim;
  string e_req = "R1";

  function automatic int wrap16(longint v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic int mul_re(int dr, int di, int wr, int wi);
    longint a;
    a = longint'(dr) * wr - longint'(di) * wi + 16384;
    return wrap16(a >>> 15);
  endfunction

  function automatic int mul_im(int dr, int di, int wr, int wi);
    longint a;
    a = longint'(dr) * wi + longint'(di) * wr + 16384;
    return wrap16(a >>> 15);
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  task automatic compare();
    chk(e_req, "sum_valid", int'(sum_valid), int'(e_sv));
    chk(e_req, "prod_valid", int'(prod_valid), int'(e_pv));
    if (e_sv) begin
      chk(e_req, "sum_re", int'(sum_re), e_sre);
      chk(e_req, "sum_im", int'(sum_im), e_sim);
    end
    if (e_pv) begin
      chk(e_req, "prod_re", int'(prod_re), e_pre);
      chk(e_req, "prod_im", int'(prod_im), e_pim);
    end
  endtask

  // one cycle: check the previous cycle's results, drive, predict
  task automatic step(bit iv, bit md, bit fl, int a, int xr, int xi, int yr,
                      int yi, int wr, int wi, string req);
    int dr, di;
    bit tk;
    @(negedge clk);
    compare();
    in_valid = iv; mode = md; flush = fl; addr = AW'(a);
    x_re = 16'(xr); x_im = 16'(xi); y_re = 16'(yr); y_im = 16'(yi);
    tw_re = 16'(wr); tw_im = 16'(wi);
    e_req = req;
    e_sv  = iv;
    e_sre = (xr + yr) >>> 1;
    e_sim = (xi + yi) >>> 1;
    dr    = (xr - yr) >>> 1;
    di    = (xi - yi) >>> 1;
    e_pv  = 0;
    if (md) begin
      if (iv) begin
        e_pv = 1; e_pre = mul_re(dr, di, wr, wi); e_pim = mul_im(dr, di, wr, wi);
      end
    end else begin
      tk = iv | fl;
      if (tk && occ[a]) begin
        e_pv  = 1;
        e_pre = mul_re(park_re[a], park_im[a], wr, wi);
        e_pim = mul_im(park_re[a], park_im[a], wr, wi);
      end
      if (iv) begin
        park_re[a] = dr; park_im[a] = di; occ[a] = 1;
      end else if (tk) begin
        occ[a] = 0;
      end
    end
  endtask

  task automatic idle(string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin occ[i] = 0; park_re[i] = 0; park_im[i] = 0; end
    rst_n = 1'b0; in_valid = 0; mode = 0; flush = 0; addr = '0;
    x_re = 0; x_im = 0; y_re = 0; y_im = 0; tw_re = 0; tw_im = 0;
    repeat (3) @(negedge clk);
    chk("R1", "sum_valid in reset", int'(sum_valid), 0);
    chk("R1", "prod_valid in reset", int'(prod_valid), 0);
    rst_n = 1'b1;
    repeat (3) idle("R1");

    // R2/R3/R4: direct mode, extremes and signs
    step(1, 1, 0, 0, 1000, -2000, 300, 500, 32767, 0, "R3");
    step(1, 1, 0, 1, 32767, 32767, -32768, -32768, -32768, 0, "R4");
    step(1, 1, 0, 2, -32768, 32767, 32767, -32768, 23170, -23170, "R4");
    step(1, 1, 0, 3, 7, -7, 2, 3, 0, 32767, "R2");
    step(1, 1, 0, 3, 7, -7, 2, 3, -12345, 555, "R2");
    step(1, 1, 1, 4, -1, -1, 0, 0, 16384, 16384, "R9");
    // R3: direct cycles must not have parked anything
    step(0, 0, 1, 0, 0, 0, 0, 0, 32767, 0, "R3");
    step(0, 0, 1, 4, 0, 0, 0, 0, 32767, 0, "R3");
    idle("R1");

    // R5: first deferred pass, entries empty
    for (int k = 0; k < 8; k++)
      step(1, 0, 0, k, 100 * k + 17, -50 * k, -9 * k, 300 - k, 20000, -3000, "R5");
    // R6/R8: second pass, parked value multiplied while new one stored
    for (int k = 0; k < 8; k++)
      step(1, 0, 0, k, -400 * k, 77 * k + 3, 1200, -k, 23170 - 1000 * k, 23170, "R8");
    // R9: flush alongside in_valid acts as plain in_valid
    step(1, 0, 1, 2, 5000, 6000, -7000, 8000, -32768, 32767, "R9");
    step(1, 0, 0, 2, 1, 2, 3, 4, 32767, -32768, "R6");
    // R7: drain then drain again
    for (int k = 0; k < 8; k++)
      step(0, 0, 1, k, 0, 0, 0, 0, 30000 - 2000 * k, 1000 * k, "R7");
    for (int k = 0; k < 8; k++)
      step(0, 0, 1, k, 0, 0, 0, 0, 12345, 0, "R7");
    idle("R1");
    idle("R1");

    // random mix of both modes
    for (int n = 0; n < 400; n++)
      step(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 3) == 0),
           bit'($urandom_range(0, 2) == 0), $urandom_range(0, DEPTH - 1),
           $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
           $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
           $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768, "R4");
    idle("R1");
    idle("R1");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule